// File: doc/BRIEF.md
# Sensor Register Serial Slave

This block is the serial-port front end of a small temperature sensor. An external master drives a serial clock, a frame select, and a data-in line. It reads replies on a data-out line that has an enable flag beside it. Every access opens with an 8-bit command that carries a read or write flag, a 3-bit register address and a repeat flag. The block then moves 8 or 16 data bits, and the width of the addressed register sets which. The serial clock idles high. Data-in is taken on rising serial-clock edges and data-out changes on falling edges. All serial inputs are sampled by the system clock, so the serial clock must be several times slower.

There are three registers:
- a read-only status register at address 0;
- a read/write 8-bit setup register at address 1;
- a read-only 16-bit temperature register at address 2, loaded from a parallel input that stands in for the measurement path.

A 32-bit run of ones on data-in resets the interface and all registers, even when the frame select is held low for three-wire use. A busy window follows, during which commands are dropped.

The framing state machine has three states. `ST_CMD` collects command bits. `ST_READ` returns data. `ST_WRITE` collects write data. It makes these transitions:
- **accept-read**: `ST_CMD` to `ST_READ` on the 8th bit of a valid read command.
- **accept-write**: `ST_CMD` to `ST_WRITE` on the 8th bit of a valid write command.
- **reject**: stays in `ST_CMD` after an invalid command or a command that arrives while busy.
- **read-done**: `ST_READ` to `ST_CMD` after the last data bit.
- **repeat**: stays in `ST_READ` at the last bit when the repeat flag was set on the temperature register.
- **write-done**: `ST_WRITE` to `ST_CMD` after the last data bit.
- **abort**: any state to `ST_CMD` when the frame select goes high or a ones-run reset fires.

Top module: `spi_sensor_slave`

## Requirements
- R1: A command is 8 bits, MSB first. Bit 7 must be 0, bit 6 is 1 for read, bits 5..3 are the address, bit 2 is the repeat flag, and bits 1..0 must be 0. A command that breaks a fixed-zero bit returns no data and changes nothing.
- R2: A read returns the addressed register MSB first: 8 bits for address 0 (status) and address 1 (setup), 16 bits for address 2 (temperature). Addresses 3..7 return 8 zero bits.
- R3: The first data bit appears on `dout` at the first falling `sclk` edge after the command. `dout_en` is 0 up to that edge, 1 while data is returned, and 0 whenever `cs_n` is high.
- R4: A write carries 8 data bits, or 16 for address 2. Only the setup register takes writes, and it changes only after its last bit. Writes to status, temperature and unmapped addresses are ignored.
- R5: Raising `cs_n` in the middle of a command or data phase abandons it without changing any register, and the next frame decodes a fresh command.
- R6: A temperature read with the repeat flag set returns the current temperature again for each further 16 clocks, with no new command. Without the flag, later clocks are decoded as a new command.
- R7: 32 consecutive ones sampled on `din` with `cs_n` low reset the interface and return status to 0x80, setup to 0x00 and temperature to 0x0000. A run of 31 ones does not, and a high `cs_n` clears the run count.
- R8: After a ones-run reset, `busy` is 1 for exactly `BUSY_CYCLES` system clocks, and commands completed in that window are ignored.
- R9: With `cs_n` held low throughout, back-to-back commands are framed by bit counts alone.
- R10: `temp_load` copies `temp_in` into the temperature register and clears status bit 7, which is 1 after any reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| sclk | input | 1 | Serial clock, idles high |
| cs_n | input | 1 | Active-low frame select |
| din | input | 1 | Serial data from the master |
| temp_in | input | 16 | New temperature sample |
| temp_load | input | 1 | Load strobe for `temp_in` |
| dout | output | 1 | Serial data to the master |
| dout_en | output | 1 | High while `dout` carries read data |
| busy | output | 1 | High during the post-reset window |

## Verification
The bench targets these corner cases, with the fault each one would expose:
- **Data-enable timing.** `dout_en` is checked right after the 8th command bit and again at the next falling edge. A design that drove the first bit one edge early or late would show up here.
- **Ones-run threshold.** Runs of 31 ones, and runs split by a `cs_n` pulse, are sent. A counter that is off by one, or that the frame select does not clear, would wrongly reset the setup register.
- **Repeat mode.** The temperature changes between repeated 16-bit groups, so a design that latched the value once would return stale data.
- **Busy window.** Its length is measured in clocks, and a command is sent inside it. A window that is too short would let that command return data.

// File: rtl/spi_sens_pkg.sv
package spi_sens_pkg;

    typedef enum logic [1:0] {
        ST_CMD   = 2'd0,
        ST_READ  = 2'd1,
        ST_WRITE = 2'd2
    } frame_state_t;

    localparam int ADDR_W = 3;
    localparam int WORD_W = 16;
    localparam int BYTE_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_STAT = 3'd0;
    localparam logic [ADDR_W-1:0] ADDR_CFG  = 3'd1;
    localparam logic [ADDR_W-1:0] ADDR_TEMP = 3'd2;

    localparam logic [BYTE_W-1:0] STAT_POR = 8'h80;

endpackage

// File: rtl/ones_run_watch.sv
module ones_run_watch #(
    parameter int RUN_LEN = 32
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic bit_rise,
    input  logic din,
    output logic hit
);
    localparam int CNT_W = $clog2(RUN_LEN);

    logic [CNT_W-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
            hit     <= 1'b0;
        end else begin
            hit <= 1'b0;
            if (clear) begin
                run_cnt <= '0;
            end else if (bit_rise) begin
                if (!din) begin
                    run_cnt <= '0;
                end else if (run_cnt == CNT_W'(RUN_LEN - 1)) begin
                    run_cnt <= '0;
                    hit     <= 1'b1;
                end else begin
                    run_cnt <= run_cnt + 1'b1;
                end
            end
        end
    end

    assert_hit_after_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ($past(din) && $past(bit_rise) && !$past(clear)));

endmodule

// File: rtl/busy_window.sv
module busy_window #(
    parameter int CYCLES = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] left;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          left <= '0;
        else if (start)      left <= CNT_W'(CYCLES);
        else if (left != '0) left <= left - 1'b1;
    end

    assign busy = (left != '0);

    assert_busy_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

endmodule

// File: rtl/sens_regs.sv
module sens_regs
    import spi_sens_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              temp_load,
    input  logic [WORD_W-1:0] temp_in,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wr_data,
    output logic [WORD_W-1:0] rd_data
);
    logic [BYTE_W-1:0] cfg_q;
    logic [WORD_W-1:0] temp_q;
    logic              no_sample_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q       <= '0;
            temp_q      <= '0;
            no_sample_q <= 1'b1;
        end else if (soft_rst) begin
            cfg_q       <= '0;
            temp_q      <= '0;
            no_sample_q <= 1'b1;
        end else begin
            if (temp_load) begin
                temp_q      <= temp_in;
                no_sample_q <= 1'b0;
            end
            if (wr_en && addr == ADDR_CFG) cfg_q <= wr_data[BYTE_W-1:0];
        end
    end

    always_comb begin
        unique case (addr)
            ADDR_STAT: rd_data = {8'h00, no_sample_q, 7'b0};
            ADDR_CFG:  rd_data = {8'h00, cfg_q};
            ADDR_TEMP: rd_data = temp_q;
            default:   rd_data = '0;
        endcase
    end

    assert_temp_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !temp_load && !soft_rst) |=> $stable(temp_q));

    assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !soft_rst) |=> $stable(cfg_q));

endmodule

// File: rtl/spi_sensor_slave.sv
module spi_sensor_slave
    import spi_sens_pkg::*;
#(
    parameter int BUSY_CYCLES = 100,
    parameter int RESET_ONES  = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        sclk,
    input  logic        cs_n,
    input  logic        din,
    input  logic [15:0] temp_in,
    input  logic        temp_load,
    output logic        dout,
    output logic        dout_en,
    output logic        busy
);
    localparam logic [3:0] LAST_NARROW = 4'(BYTE_W - 1);
    localparam logic [3:0] LAST_WIDE   = 4'(WORD_W - 1);

    frame_state_t state, state_d;

    logic              sclk_q;
    logic              rise, fall;
    logic              soft_rst;
    logic [3:0]        cnt;
    logic [7:0]        cmd_sr;
    logic [ADDR_W-1:0] addr_q;
    logic              cont_q, wide_q, need_load;
    logic [WORD_W-1:0] shreg, wsr, wr_data_q, rd_data, rd_word;
    logic              dout_q, en_q, wr_en_q;

    assign rise = ~cs_n & sclk & ~sclk_q;
    assign fall = ~cs_n & ~sclk & sclk_q;

    wire [7:0] cmd_full   = {cmd_sr[6:0], din};
    wire       cmd_ok     = ~cmd_full[7] & (cmd_full[1:0] == 2'b00) & ~busy;
    wire [3:0] last_idx   = wide_q ? LAST_WIDE : LAST_NARROW;
    wire       repeat_rd  = cont_q & wide_q;

    assign rd_word = wide_q ? rd_data : {rd_data[7:0], 8'h00};

    ones_run_watch #(.RUN_LEN(RESET_ONES)) u_ones (
        .clk(clk), .rst_n(rst_n), .clear(cs_n), .bit_rise(rise),
        .din(din), .hit(soft_rst)
    );

    busy_window #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk(clk), .rst_n(rst_n), .start(soft_rst), .busy(busy)
    );

    sens_regs u_regs (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst),
        .temp_load(temp_load), .temp_in(temp_in),
        .wr_en(wr_en_q), .addr(addr_q), .wr_data(wr_data_q),
        .rd_data(rd_data)
    );

    always_comb begin
        state_d = state;
        if (cs_n || soft_rst) begin
            state_d = ST_CMD;
        end else if (rise) begin
            unique case (state)
                ST_CMD:   if (cnt == LAST_NARROW && cmd_ok)
                              state_d = cmd_full[6] ? ST_READ : ST_WRITE;
                ST_READ:  if (cnt == last_idx && !repeat_rd) state_d = ST_CMD;
                ST_WRITE: if (cnt == last_idx) state_d = ST_CMD;
                default:  state_d = ST_CMD;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_CMD;
        else        state <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q    <= 1'b1;
            cnt       <= '0;
            cmd_sr    <= '0;
            addr_q    <= '0;
            cont_q    <= 1'b0;
            wide_q    <= 1'b0;
            need_load <= 1'b0;
            shreg     <= '0;
            wsr       <= '0;
            wr_data_q <= '0;
            dout_q    <= 1'b0;
            en_q      <= 1'b0;
            wr_en_q   <= 1'b0;
        end else begin
            sclk_q  <= sclk;
            wr_en_q <= 1'b0;
            if (cs_n || soft_rst) begin
                cnt       <= '0;
                en_q      <= 1'b0;
                need_load <= 1'b0;
            end else begin
                if (rise) begin
                    unique case (state)
                        ST_CMD: begin
                            cmd_sr <= cmd_full;
                            if (cnt == LAST_NARROW) begin
                                cnt <= '0;
                                if (cmd_ok) begin
                                    addr_q    <= cmd_full[5:3];
                                    cont_q    <= cmd_full[2];
                                    wide_q    <= (cmd_full[5:3] == ADDR_TEMP);
                                    need_load <= 1'b1;
                                end
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_READ: begin
                            if (cnt == last_idx) begin
                                cnt       <= '0;
                                need_load <= repeat_rd;
                                if (!repeat_rd) en_q <= 1'b0;
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        ST_WRITE: begin
                            wsr <= {wsr[14:0], din};
                            if (cnt == last_idx) begin
                                cnt       <= '0;
                                wr_en_q   <= 1'b1;
                                wr_data_q <= {wsr[14:0], din};
                            end else begin
                                cnt <= cnt + 1'b1;
                            end
                        end
                        default: cnt <= '0;
                    endcase
                end
                if (fall && state == ST_READ) begin
                    en_q      <= 1'b1;
                    need_load <= 1'b0;
                    if (need_load) begin
                        dout_q <= rd_word[15];
                        shreg  <= {rd_word[14:0], 1'b0};
                    end else begin
                        dout_q <= shreg[15];
                        shreg  <= {shreg[14:0], 1'b0};
                    end
                end
            end
        end
    end

    assign dout    = dout_q;
    assign dout_en = en_q;

    assert_cmd_cnt_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD) |-> (cnt <= LAST_NARROW));

    assert_dout_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n)) |-> !dout_en);

    assert_busy_drops_cmd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && state == ST_CMD) |=> (state == ST_CMD));

    assert_read_only_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CMD && $past(state) == ST_CMD) |-> !dout_en);

endmodule

// File: tb/test_spi_sensor_slave.sv
module test_spi_sensor_slave;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int BUSY       = 200;

    logic        clk = 1'b0;
    logic        rst_n, sclk, cs_n, din, temp_load;
    logic [15:0] temp_in;
    logic        dout, dout_en, busy;

    int nchk = 0;
    int nfail = 0;
    int busy_run = 0;
    int busy_len = 0;
    int busy_runs = 0;
    logic three_wire = 1'b0;
    logic [7:0]  exp_cfg, exp_stat;
    logic [15:0] exp_temp;

    spi_sensor_slave #(.BUSY_CYCLES(BUSY), .RESET_ONES(32)) i_spi_sensor_slave (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .din(din),
        .temp_in(temp_in), .temp_load(temp_load),
        .dout(dout), .dout_en(dout_en), .busy(busy)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) begin
        if (busy) busy_run <= busy_run + 1;
        else if (busy_run != 0) begin
            busy_len  <= busy_run;
            busy_runs <= busy_runs + 1;
            busy_run  <= 0;
        end
    end

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        nchk++; nfail++;
        $display("FAIL watchdog: run hung got=0 exp=1");
        summary();
    end

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        nchk++;
        if (got !== exp) begin
            nfail++;
            $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
        end
    endtask

    task automatic bits(input logic [15:0] val, input int n,
                        output logic [15:0] got, output logic en_all, output logic en_any);
        got = '0; en_all = 1'b1; en_any = 1'b0;
        for (int i = n - 1; i >= 0; i--) begin
            @(negedge clk); sclk = 1'b0; din = val[i];
            repeat (HALF) @(negedge clk);
            got = {got[14:0], dout};
            en_all &= dout_en; en_any |= dout_en;
            sclk = 1'b1;
            repeat (HALF) @(negedge clk);
        end
    endtask

    function automatic logic [7:0] mk(logic rd, logic [2:0] a, logic cont);
        return {1'b0, rd, a, cont, 2'b00};
    endfunction

    task automatic xact(input logic [7:0] cmd, input int n, input logic [15:0] wd,
                        output logic [15:0] got, output logic en_all,
                        output logic en_any, output logic pre_en);
        logic [15:0] g; logic a, b;
        cs_n = 1'b0;
        bits({8'h00, cmd}, 8, g, a, b);
        pre_en = dout_en;
        bits(wd, n, got, en_all, en_any);
        if (!three_wire) begin
            cs_n = 1'b1;
            repeat (4) @(negedge clk);
        end
    endtask

    task automatic rd_chk(string tag, input logic [2:0] a, input logic [15:0] exp);
        logic [15:0] got; logic ea, en, pe; int n;
        n = (a == 3'd2) ? 16 : 8;
        xact(mk(1'b1, a, 1'b0), n, 16'h0, got, ea, en, pe);
        chk({tag, " data"}, got, exp);
        chk({tag, " en during data"}, ea, 1'b1);
        chk({tag, " en before first fall"}, pe, 1'b0);
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] v);
        logic [15:0] got; logic ea, en, pe;
        xact(mk(1'b0, a, 1'b0), (a == 3'd2) ? 16 : 8, v, got, ea, en, pe);
    endtask

    task automatic load_temp(input logic [15:0] v);
        @(negedge clk); temp_in = v; temp_load = 1'b1;
        @(negedge clk); temp_load = 1'b0;
        exp_temp = v; exp_stat = 8'h00;
    endtask

    initial begin
        logic [15:0] got; logic ea, en, pe;
        rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b1; din = 1'b0;
        temp_in = '0; temp_load = 1'b0;
        exp_cfg = 8'h00; exp_stat = 8'h80; exp_temp = 16'h0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        chk("R3 reset dout_en", dout_en, 1'b0);
        chk("R8 reset busy", busy, 1'b0);
        rd_chk("R10 status after reset", 3'd0, 16'h0080);
        rd_chk("R2 setup after reset", 3'd1, 16'h0000);
        rd_chk("R2 temp after reset", 3'd2, 16'h0000);

        load_temp(16'hA5C3);
        rd_chk("R10 status after load", 3'd0, 16'h0000);
        rd_chk("R10 temp after load", 3'd2, 16'hA5C3);

        for (int v = 0; v < 256; v += 17) begin
            wr(3'd1, 16'(v));
            exp_cfg = 8'(v);
            rd_chk("R4 setup write sweep", 3'd1, {8'h00, exp_cfg});
        end

        for (int a = 0; a < 8; a++) begin
            logic [15:0] e;
            e = (a == 0) ? {8'h00, exp_stat} : (a == 1) ? {8'h00, exp_cfg} :
                (a == 2) ? exp_temp : 16'h0;
            rd_chk("R2 address sweep", 3'(a), e);
        end

        wr(3'd0, 16'h00FF);
        wr(3'd2, 16'h1234);
        for (int a = 3; a < 8; a++) wr(3'(a), 16'h00FF);
        rd_chk("R4 status write ignored", 3'd0, {8'h00, exp_stat});
        rd_chk("R4 temp write ignored", 3'd2, exp_temp);
        rd_chk("R4 unmapped write ignored", 3'd1, {8'h00, exp_cfg});

        xact(8'hC8, 8, 16'h0, got, ea, en, pe);
        chk("R1 bit7 set returns nothing", en, 1'b0);
        xact(8'h4A, 8, 16'h0, got, ea, en, pe);
        chk("R1 bit1 set returns nothing", en, 1'b0);
        xact(8'h09, 8, 16'h0033, got, ea, en, pe);
        rd_chk("R1 bad write changes nothing", 3'd1, {8'h00, exp_cfg});

        wr(3'd1, 16'h0011); exp_cfg = 8'h11;
        cs_n = 1'b0;
        bits({8'h00, mk(1'b0, 3'd1, 1'b0)}, 8, got, ea, en);
        bits(16'h000E, 4, got, ea, en);
        cs_n = 1'b1; repeat (4) @(negedge clk);
        rd_chk("R5 abort in data phase", 3'd1, 16'h0011);
        cs_n = 1'b0;
        bits(16'h0004, 4, got, ea, en);
        cs_n = 1'b1; repeat (4) @(negedge clk);
        rd_chk("R5 abort in command phase", 3'd1, 16'h0011);

        cs_n = 1'b0;
        bits({8'h00, mk(1'b1, 3'd2, 1'b1)}, 8, got, ea, en);
        for (int k = 0; k < 3; k++) begin
            logic [15:0] t;
            t = 16'h1111 * 16'(k + 3) ^ 16'h0F0F;
            load_temp(t);
            bits(16'h0, 16, got, ea, en);
            chk("R6 repeat group data", got, t);
            chk("R6 repeat group enable", ea, 1'b1);
        end
        cs_n = 1'b1; repeat (4) @(negedge clk);
        cs_n = 1'b0;
        bits({8'h00, mk(1'b1, 3'd2, 1'b0)}, 8, got, ea, en);
        bits(16'h0, 16, got, ea, en);
        chk("R6 plain temp read", got, exp_temp);
        bits(16'h0, 8, got, ea, en);
        chk("R6 no repeat without flag", en, 1'b0);
        cs_n = 1'b1; repeat (4) @(negedge clk);

        three_wire = 1'b1;
        cs_n = 1'b0;
        wr(3'd1, 16'h003C); exp_cfg = 8'h3C;
        rd_chk("R9 three-wire setup", 3'd1, 16'h003C);
        rd_chk("R9 three-wire temp", 3'd2, exp_temp);
        rd_chk("R9 three-wire status", 3'd0, 16'h0000);

        bits(16'hFFFF, 16, got, ea, en);
        bits(16'hFFFE, 16, got, ea, en);
        chk("R7 31 ones no busy", busy, 1'b0);
        chk("R7 31 ones no reset run", busy_runs, 0);
        rd_chk("R7 31 ones setup kept", 3'd1, 16'h003C);

        bits(16'hFFFF, 16, got, ea, en);
        bits(16'hFFFF, 16, got, ea, en);
        chk("R8 busy after 32 ones", busy, 1'b1);
        xact(mk(1'b1, 3'd1, 1'b0), 8, 16'h0, got, ea, en, pe);
        chk("R8 command ignored while busy", en, 1'b0);
        for (int w = 0; w < 400 && busy; w++) @(negedge clk);
        repeat (2) @(negedge clk);
        chk("R8 busy window length", busy_len, BUSY);
        exp_cfg = 8'h00; exp_stat = 8'h80; exp_temp = 16'h0;
        rd_chk("R7 setup after ones reset", 3'd1, 16'h0000);
        rd_chk("R7 status after ones reset", 3'd0, 16'h0080);
        rd_chk("R7 temp after ones reset", 3'd2, 16'h0000);

        three_wire = 1'b0;
        cs_n = 1'b1; repeat (4) @(negedge clk);
        wr(3'd1, 16'h005A); exp_cfg = 8'h5A;
        cs_n = 1'b0;
        bits(16'hFFFF, 16, got, ea, en);
        bits(16'h000F, 4, got, ea, en);
        cs_n = 1'b1; repeat (4) @(negedge clk);
        cs_n = 1'b0;
        bits(16'hFFF0, 16, got, ea, en);
        cs_n = 1'b1; repeat (4) @(negedge clk);
        chk("R7 cs clears ones count", busy_runs, 1);
        rd_chk("R7 split run setup kept", 3'd1, 16'h005A);

        summary();
    end
endmodule